// File: doc/BRIEF.md
# Overlapped Weight-Load / Compute Layer Scheduler

This block sequences a neural-network run across a ring of compute tiles. Layer `l` is placed on tile `l mod NUM_TILES`. Each tile holds a four-state controller: idle, loading weights, loaded and waiting, computing. The scheduler keeps two command streams. The load stream sends start-reprogram pulses and the compute stream sends start-compute pulses. The tiles answer with reprogram-done and compute-done tokens.

The window is two layers deep. Weight loading for layer `l+1` begins in the same cycle as compute for layer `l`. Compute for `l+1` waits until `l` has finished and the weights of `l+1` are in place. Each cycle in which the finished pipeline waits on a load still in progress adds one to a stall counter. The first layer has nothing to overlap with, so its load runs on its own.

A run begins with a pulse on `run_start`, which carries the layer count. It ends with a sticky `run_done` flag. If a done token reaches a tile that is not in the matching state, a sticky error flag is set.

Top module: `overlap_layer_sched`

## Requirements
- R1: After reset, all start pulses, `stall_count`, `run_done` and `proto_err` are zero.
- R2: Layer `l` is loaded on tile `l mod NUM_TILES`. For every layer after the first, the load pulse is issued in the same cycle as the compute pulse of the layer before it.
- R3: Layer `l` computes on tile `l mod NUM_TILES`. Layers start compute in order, and `comp_start` is at most one-hot.
- R4: No compute is issued for the first layer until its load has finished. Its compute pulse comes in the cycle after its reprogram-done token, and no second load is issued before then.
- R5: For `l` ≥ 1, the compute pulse for layer `l` comes in the cycle after the later of two tokens: compute-done of layer `l-1` and reprogram-done of layer `l`.
- R6: `stall_count` adds one for each cycle in which the previous layer has finished computing while the next layer's tile is still loading. With load time R and compute time C per layer, a run of N layers ends with (N-1)·max(0, R−C). An accepted `run_start` clears the counter.
- R7: `run_done` rises in the cycle after the last layer's compute-done and stays high until the next accepted `run_start`. Exactly N loads are issued per run, and no pulses are issued while `run_done` is high.
- R8: A reprogram-done token to a tile that is not loading, or a compute-done token to a tile that is not computing, sets `proto_err` in the next cycle. Only reset clears it.
- R9: A `run_start` that arrives while a run is in progress is ignored. The layer count stays the one originally latched.
- R10: A `run_start` with a layer count of zero raises `run_done` in the next cycle and issues no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_start | input | 1 | Begin a run (accepted only while idle) |
| num_layers | input | LAYER_W | Layer count, latched on an accepted `run_start` |
| reprog_done | input | NUM_TILES | Per-tile weight-load finished token |
| comp_done | input | NUM_TILES | Per-tile compute finished token |
| reprog_start | output | NUM_TILES | Per-tile start-weight-load pulse |
| comp_start | output | NUM_TILES | Per-tile start-compute pulse |
| stall_count | output | STALL_W | Saturating count of overlap stall cycles |
| run_done | output | 1 | Sticky end-of-run flag |
| proto_err | output | 1 | Sticky token-out-of-order flag |

## Verification
The table runs pair load time against compute time in three ways. Load shorter than compute checks that the stall counter stays at zero and that the compute pulse waits for compute-done. Load longer than compute checks that the stall equals the per-layer excess and that the compute pulse waits for reprogram-done. Equal lengths check the tie, where both tokens arrive in the same cycle. Run lengths of one layer, fewer layers than tiles, and more layers than tiles check the single-layer case and the wrap-around of tile indices. Directed runs cover a zero-layer start, a second start during a run, and a stray done token.

// File: rtl/ovl_sched_pkg.sv
package ovl_sched_pkg;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_LOAD  = 2'd1,
        TS_READY = 2'd2,
        TS_COMP  = 2'd3
    } tile_state_e;

endpackage

// File: rtl/ovl_tile_fsm.sv
module ovl_tile_fsm
    import ovl_sched_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_load,
    input  logic        go_comp,
    input  logic        load_done,
    input  logic        comp_done,
    output tile_state_e state_o,
    output logic        token_err_o
);

    typedef struct packed {
        tile_state_e st;
    } tile_regs_t;

    tile_regs_t tile_d, tile_q;
    logic       err_d;

    always_comb begin
        tile_d = tile_q;
        unique case (tile_q.st)
            TS_IDLE:  if (go_load)   tile_d.st = TS_LOAD;
            TS_LOAD:  if (load_done) tile_d.st = TS_READY;
            TS_READY: if (go_comp)   tile_d.st = TS_COMP;
            TS_COMP:  if (comp_done) tile_d.st = TS_IDLE;
            default:                 tile_d.st = TS_IDLE;
        endcase
        // A token is legal only in the state that is waiting for it
        err_d = (load_done && (tile_q.st != TS_LOAD)) ||
                (comp_done && (tile_q.st != TS_COMP));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tile_q <= '{st: TS_IDLE};
        else        tile_q <= tile_d;
    end

    assign state_o     = tile_q.st;
    assign token_err_o = err_d;

endmodule

// File: rtl/ovl_stall_counter.sv
module ovl_stall_counter #(
    parameter int STALL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               inc,
    output logic [STALL_W-1:0] count_o
);

    localparam logic [STALL_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [STALL_W-1:0] cnt;
    } stall_regs_t;

    stall_regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)                            st_d.cnt = '0;
        else if (inc && st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

endmodule

// File: rtl/ovl_layer_sequencer.sv
module ovl_layer_sequencer #(
    parameter int NUM_TILES = 4,
    parameter int LAYER_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_start,
    input  logic [LAYER_W-1:0]   num_layers,
    input  logic [NUM_TILES-1:0] comp_done,
    input  logic [NUM_TILES-1:0] tile_idle,
    input  logic [NUM_TILES-1:0] tile_load,
    input  logic [NUM_TILES-1:0] tile_ready,
    input  logic [NUM_TILES-1:0] tile_comp,
    input  logic [NUM_TILES-1:0] tile_err,
    output logic [NUM_TILES-1:0] go_load,
    output logic [NUM_TILES-1:0] go_comp,
    output logic                 stall_inc,
    output logic                 stall_clr,
    output logic                 run_done,
    output logic                 proto_err
);

    localparam int TILE_W = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1;
    localparam logic [TILE_W-1:0] LAST_TILE = TILE_W'(NUM_TILES - 1);

    typedef struct packed {
        logic               running;
        logic [LAYER_W-1:0] n_layers;
        logic [LAYER_W-1:0] ld_idx;
        logic [TILE_W-1:0]  ld_tile;
        logic [LAYER_W-1:0] cp_idx;
        logic [TILE_W-1:0]  cp_tile;
        logic               done;
        logic               err;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    function automatic logic [TILE_W-1:0] step_tile(input logic [TILE_W-1:0] t);
        return (t == LAST_TILE) ? '0 : t + 1'b1;
    endfunction

    logic any_comp;
    logic last_finish;

    always_comb begin
        seq_d       = seq_q;
        go_load     = '0;
        go_comp     = '0;
        stall_inc   = 1'b0;
        stall_clr   = 1'b0;
        any_comp    = |tile_comp;
        last_finish = 1'b0;

        if (|tile_err) seq_d.err = 1'b1;

        if (!seq_q.running) begin
            if (run_start) begin
                seq_d.running  = (num_layers != '0);
                seq_d.done     = (num_layers == '0);
                seq_d.n_layers = num_layers;
                seq_d.ld_idx   = '0;
                seq_d.ld_tile  = '0;
                seq_d.cp_idx   = '0;
                seq_d.cp_tile  = '0;
                stall_clr      = 1'b1;
            end
        end else begin
            // Compute stream: one layer at a time, in order, once loaded
            if (!any_comp && (seq_q.cp_idx < seq_q.n_layers) &&
                tile_ready[seq_q.cp_tile]) begin
                go_comp[seq_q.cp_tile] = 1'b1;
                seq_d.cp_idx  = seq_q.cp_idx + 1'b1;
                seq_d.cp_tile = step_tile(seq_q.cp_tile);
            end else if (!any_comp && (seq_q.cp_idx != '0) &&
                         (seq_q.cp_idx < seq_q.n_layers) &&
                         tile_load[seq_q.cp_tile]) begin
                stall_inc = 1'b1;
            end

            // Load stream: at most one layer ahead of the compute stream
            if ((seq_q.ld_idx < seq_q.n_layers) &&
                (seq_q.ld_idx == seq_d.cp_idx) &&
                tile_idle[seq_q.ld_tile]) begin
                go_load[seq_q.ld_tile] = 1'b1;
                seq_d.ld_idx  = seq_q.ld_idx + 1'b1;
                seq_d.ld_tile = step_tile(seq_q.ld_tile);
            end

            last_finish = (seq_q.cp_idx == seq_q.n_layers) &&
                          (|(comp_done & tile_comp));
            if (last_finish) begin
                seq_d.running = 1'b0;
                seq_d.done    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign run_done  = seq_q.done;
    assign proto_err = seq_q.err;

endmodule

// File: rtl/overlap_layer_sched.sv
module overlap_layer_sched
    import ovl_sched_pkg::*;
#(
    parameter int NUM_TILES = 4,
    parameter int LAYER_W   = 8,
    parameter int STALL_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_start,
    input  logic [LAYER_W-1:0]   num_layers,
    input  logic [NUM_TILES-1:0] reprog_done,
    input  logic [NUM_TILES-1:0] comp_done,
    output logic [NUM_TILES-1:0] reprog_start,
    output logic [NUM_TILES-1:0] comp_start,
    output logic [STALL_W-1:0]   stall_count,
    output logic                 run_done,
    output logic                 proto_err
);

    logic [NUM_TILES-1:0] tile_idle, tile_load, tile_ready, tile_comp, tile_err;
    logic [NUM_TILES-1:0] go_load, go_comp;
    logic                 stall_inc, stall_clr;

    generate
        for (genvar g = 0; g < NUM_TILES; g++) begin : g_tile
            tile_state_e st;
            ovl_tile_fsm u_tile (
                .clk         (clk),
                .rst_n       (rst_n),
                .go_load     (go_load[g]),
                .go_comp     (go_comp[g]),
                .load_done   (reprog_done[g]),
                .comp_done   (comp_done[g]),
                .state_o     (st),
                .token_err_o (tile_err[g])
            );
            assign tile_idle[g]  = (st == TS_IDLE);
            assign tile_load[g]  = (st == TS_LOAD);
            assign tile_ready[g] = (st == TS_READY);
            assign tile_comp[g]  = (st == TS_COMP);
        end
    endgenerate

    ovl_layer_sequencer #(
        .NUM_TILES (NUM_TILES),
        .LAYER_W   (LAYER_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_start  (run_start),
        .num_layers (num_layers),
        .comp_done  (comp_done),
        .tile_idle  (tile_idle),
        .tile_load  (tile_load),
        .tile_ready (tile_ready),
        .tile_comp  (tile_comp),
        .tile_err   (tile_err),
        .go_load    (go_load),
        .go_comp    (go_comp),
        .stall_inc  (stall_inc),
        .stall_clr  (stall_clr),
        .run_done   (run_done),
        .proto_err  (proto_err)
    );

    ovl_stall_counter #(
        .STALL_W (STALL_W)
    ) u_stall (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (stall_clr),
        .inc     (stall_inc),
        .count_o (stall_count)
    );

    assign reprog_start = go_load;
    assign comp_start   = go_comp;

endmodule

// File: rtl/ovl_sched_checker.sv
module ovl_sched_checker #(
    parameter int NUM_TILES = 4,
    parameter int STALL_W   = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 run_start,
    input logic [NUM_TILES-1:0] reprog_start,
    input logic [NUM_TILES-1:0] comp_start,
    input logic [STALL_W-1:0]   stall_count,
    input logic                 run_done,
    input logic                 proto_err
);

    // R3: compute stream drives at most one tile per cycle
    a_r3_comp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(comp_start));

    // R2: load stream drives at most one tile per cycle
    a_r2_load_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reprog_start));

    // R2: the overlapped load never targets the tile being started for compute
    a_r2_split_tiles: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_start & reprog_start) == '0);

    // R7: no commands while the run is reported finished
    a_r7_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |-> (reprog_start == '0 && comp_start == '0));

    // R8: error flag holds once set
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R6: counter moves by at most one per cycle unless a start clears it
    a_r6_stall_step: assert property (@(posedge clk) disable iff (!rst_n)
        !run_start |=> ((stall_count == $past(stall_count)) ||
                        (stall_count == $past(stall_count) + 1'b1)));

endmodule

bind overlap_layer_sched ovl_sched_checker #(
    .NUM_TILES (NUM_TILES),
    .STALL_W   (STALL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_start    (run_start),
    .reprog_start (reprog_start),
    .comp_start   (comp_start),
    .stall_count  (stall_count),
    .run_done     (run_done),
    .proto_err    (proto_err)
);

// File: tb/sim_overlap_layer_sched.sv
`timescale 1ns/1ps
module sim_overlap_layer_sched;

    localparam int NT = 4;
    localparam int LW = 8;
    localparam int SW = 16;
    localparam int NV = 8;
    // {layers, load cycles, compute cycles}
    localparam int VEC [0:NV-1][0:2] = '{
        '{4, 3, 6}, '{4, 6, 3}, '{5, 5, 5}, '{1, 4, 2},
        '{3, 1, 1}, '{6, 9, 2}, '{2, 2, 8}, '{7, 4, 1}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          run_start;
    logic [LW-1:0] num_layers;
    logic [NT-1:0] reprog_done;
    logic [NT-1:0] comp_done;
    logic [NT-1:0] reprog_start;
    logic [NT-1:0] comp_start;
    logic [SW-1:0] stall_count;
    logic          run_done;
    logic          proto_err;

    overlap_layer_sched #(.NUM_TILES(NT), .LAYER_W(LW), .STALL_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .num_layers(num_layers),
        .reprog_done(reprog_done), .comp_done(comp_done),
        .reprog_start(reprog_start), .comp_start(comp_start),
        .stall_count(stall_count), .run_done(run_done), .proto_err(proto_err)
    );

    initial forever #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit summary_done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tile_of(input logic [NT-1:0] v);
        for (int i = 0; i < NT; i++) if (v[i]) return i;
        return -1;
    endfunction

    // Responder / monitor state
    int cyc = 0;
    int rp_len = 1, cp_len = 1, cur_n = 0;
    int ld_seen = 0, cp_seen = 0, cdone_last = 0;
    bit done_seen = 0, prev_rd = 0;
    int rdone [0:63];
    int cnt_r [0:NT-1];
    int cnt_c [0:NT-1];
    int lay_of [0:NT-1];
    bit jl_r [0:NT-1];
    bit jl_c [0:NT-1];
    logic [NT-1:0] inj_cdone = '0;

    initial begin
        reprog_done = '0;
        comp_done   = '0;
        for (int i = 0; i < NT; i++) begin cnt_r[i] = 0; cnt_c[i] = 0; lay_of[i] = 0; end
        for (int i = 0; i < 64; i++) rdone[i] = 0;
        forever begin
            @(negedge clk);
            cyc++;
            for (int i = 0; i < NT; i++) begin jl_r[i] = 0; jl_c[i] = 0; end
            if (rst_n) begin
                if ($countones(comp_start) > 1) begin
                    chk(0, "R3 comp onehot", $countones(comp_start), 1);
                end else if (comp_start != '0) begin
                    automatic int t = tile_of(comp_start);
                    automatic int ex;
                    chk(t == cp_seen % NT, "R3 comp tile", t, cp_seen % NT);
                    if (cp_seen == 0) begin
                        ex = rdone[0] + 1;
                        chk(cyc == ex, "R4 first compute timing", cyc, ex);
                    end else if (cp_seen < 64) begin
                        ex = ((cdone_last > rdone[cp_seen]) ? cdone_last : rdone[cp_seen]) + 1;
                        chk(cyc == ex, "R5 compute timing", cyc, ex);
                    end
                    cnt_c[t] = cp_len;
                    jl_c[t]  = 1;
                    cp_seen++;
                end
                if (reprog_start != '0) begin
                    automatic int t = tile_of(reprog_start);
                    chk(ld_seen < cur_n, "R7 extra load", ld_seen, cur_n);
                    chk(t == ld_seen % NT, "R2 load tile", t, ld_seen % NT);
                    if (ld_seen == 0)
                        chk(comp_start == '0 && cp_seen == 0, "R4 lone first load", cp_seen, 0);
                    else
                        chk(comp_start != '0 && cp_seen == ld_seen, "R2 overlap", cp_seen, ld_seen);
                    lay_of[t] = ld_seen;
                    cnt_r[t]  = rp_len;
                    jl_r[t]   = 1;
                    ld_seen++;
                end
                if (run_done && !prev_rd) begin
                    done_seen = 1;
                    if (cur_n > 0) chk(cyc == cdone_last + 1, "R7 done timing", cyc, cdone_last + 1);
                end
                prev_rd = run_done;
            end
            reprog_done = '0;
            comp_done   = inj_cdone;
            for (int i = 0; i < NT; i++) begin
                if (!jl_r[i] && cnt_r[i] > 0) begin
                    cnt_r[i]--;
                    if (cnt_r[i] == 0) begin
                        reprog_done[i] = 1'b1;
                        if (lay_of[i] < 64) rdone[lay_of[i]] = cyc;
                    end
                end
                if (!jl_c[i] && cnt_c[i] > 0) begin
                    cnt_c[i]--;
                    if (cnt_c[i] == 0) begin
                        comp_done[i] = 1'b1;
                        cdone_last = cyc;
                    end
                end
            end
        end
    end

    task automatic arm(input int n, input int r, input int c);
        rp_len = r; cp_len = c; cur_n = n;
        ld_seen = 0; cp_seen = 0; done_seen = 0;
        num_layers = LW'(n);
        run_start  = 1'b1;
        @(negedge clk);
        run_start  = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_seen) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_up();
        if (!summary_done) begin
            summary_done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        rst_n = 1'b0; run_start = 1'b0; num_layers = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk(reprog_start == '0 && comp_start == '0, "R1 pulses", int'(reprog_start | comp_start), 0);
        chk(stall_count == '0, "R1 stall", int'(stall_count), 0);
        chk(run_done == 1'b0, "R1 run_done", int'(run_done), 0);
        chk(proto_err == 1'b0, "R1 proto_err", int'(proto_err), 0);

        // R10: empty run
        arm(0, 1, 1);
        chk(run_done == 1'b1, "R10 immediate done", int'(run_done), 1);
        repeat (4) @(negedge clk);
        chk(ld_seen == 0 && cp_seen == 0, "R10 no pulses", ld_seen + cp_seen, 0);

        // Table of runs: R2..R7
        for (int v = 0; v < NV; v++) begin
            automatic int n = VEC[v][0];
            automatic int r = VEC[v][1];
            automatic int c = VEC[v][2];
            automatic int ex = (n - 1) * ((r > c) ? (r - c) : 0);
            arm(n, r, c);
            wait_done();
            chk(int'(stall_count) == ex, "R6 stall total", int'(stall_count), ex);
            chk(ld_seen == n, "R7 load count", ld_seen, n);
            chk(cp_seen == n, "R3 compute count", cp_seen, n);
            chk(run_done == 1'b1, "R7 done held", int'(run_done), 1);
            chk(proto_err == 1'b0, "R8 no error on clean run", int'(proto_err), 0);
        end

        // R9: second start mid-run is ignored
        arm(3, 2, 2);
        repeat (3) @(negedge clk);
        num_layers = LW'(9);
        run_start  = 1'b1;
        @(negedge clk);
        run_start  = 1'b0;
        wait_done();
        chk(cp_seen == 3, "R9 compute count", cp_seen, 3);
        chk(ld_seen == 3, "R9 load count", ld_seen, 3);
        chk(stall_count == '0, "R9 stall", int'(stall_count), 0);

        // R8: stray compute-done to an idle tile
        chk(proto_err == 1'b0, "R8 before", int'(proto_err), 0);
        @(posedge clk);
        inj_cdone = 4'b0010;
        @(posedge clk);
        inj_cdone = '0;
        @(negedge clk);
        chk(proto_err == 1'b1, "R8 set", int'(proto_err), 1);
        repeat (5) @(negedge clk);
        chk(proto_err == 1'b1, "R8 sticky", int'(proto_err), 1);

        finish_up();
    end

endmodule